// File: doc/BRIEF.md
# Energy-Dependent Loss Threshold and Dump Request Controller

This block takes a stream of running loss sums, one per clock, each tagged with a detector channel and an integration-window index. It compares every sum against a threshold chosen from a per-channel table, and the current beam-energy index selects the column of that table. A sum strictly above its threshold raises a dump request. A per-channel mask entry decides which of two request outputs the channel drives: the maskable request, which a safe-beam flag can suppress, or the unmaskable request, which nothing can suppress. Requests stay latched until an explicit clear pulse.

The threshold and mask tables are written through a simple write port while the block is still in its loading state. A one-cycle completion pulse then locks the tables and arms the comparison. Health and dump status also leave the block as a square wave. The wave toggles at a nominal rate while armed and at half that rate while a request is latched. It stays low before loading and after a failure, so a downstream receiver can tell a broken wire or a dead card from a working one.

The controller is built around four states. LOAD accepts table writes and ignores sums. ARMED compares sums. DUMP holds latched requests while comparison continues. FAULT is entered on a failure input and can only be left through reset. The transitions are named as follows: T_LOADED goes from LOAD to ARMED on the load-done pulse. T_TRIP goes from ARMED to DUMP on any accepted exceedance. T_CLEAR goes from DUMP to ARMED on a clear pulse that arrives with no new exceedance in the same cycle. T_FAIL goes from any state to FAULT on the failure input.

Top module: `loss_dump_ctrl`

## Requirements
- R1: After reset the block is in LOAD, with both request outputs low, the running output low and the status wave held low.
- R2: Table writes take effect only in LOAD. Once the load-done pulse has been seen, any write is ignored. For mask writes, data bit 0 is the mask-enable bit and data bit 1 is the force-unmaskable bit. Threshold writes address the entry (channel, window, energy).
- R3: A sum presented in LOAD raises no request.
- R4: The threshold used for a sum is the entry written for its own channel, its own window and the current beam energy. A request is raised only when the sum is strictly greater than that threshold. A window index at or above the window count never raises a request.
- R5: A channel whose mask-enable bit is 1 and whose force-unmaskable bit is 0 drives the maskable request on an exceedance while the safe flag is low. While the safe flag is high, its exceedances are ignored.
- R6: A channel whose mask-enable bit is 0, or whose force-unmaskable bit is 1, drives the unmaskable request on an exceedance, whatever the safe flag.
- R7: A raised request stays high until the clear input is pulsed. If a clear and a new exceedance fall in the same cycle, the new exceedance's request is set and the other request is cleared.
- R8: The running output is high exactly in ARMED and DUMP.
- R9: In ARMED the status wave toggles every DIV_NOM cycles. In DUMP it toggles every 2*DIV_NOM cycles.
- R10: The failure input moves the block to FAULT, where it stays until reset. In FAULT the running output and the status wave are low, and sums raise no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_wr_en | input | 1 | Table write strobe |
| tbl_wr_is_mask | input | 1 | 1 selects the mask table, 0 the threshold table |
| tbl_wr_ch | input | CH_W | Channel addressed by the write |
| tbl_wr_win | input | WIN_W | Window addressed by a threshold write |
| tbl_wr_energy | input | ENERGY_W | Energy column addressed by a threshold write |
| tbl_wr_data | input | SUM_W | Threshold value, or mask bits [1:0] |
| tbl_load_done | input | 1 | Pulse that locks the tables and arms the block |
| beam_energy | input | ENERGY_W | Current beam-energy column index |
| safe_beam | input | 1 | Safe condition: masking is honoured while high |
| sum_valid | input | 1 | A running sum is presented this cycle |
| sum_ch | input | CH_W | Channel of the presented sum |
| sum_win | input | WIN_W | Integration-window index of the presented sum |
| sum_value | input | SUM_W | Running-sum value |
| dump_clear | input | 1 | Pulse that clears latched requests |
| fault_in | input | 1 | Internal failure indication |
| maskable_dump_o | output | 1 | Latched maskable dump request |
| unmaskable_dump_o | output | 1 | Latched unmaskable dump request |
| card_running_o | output | 1 | Card is armed and healthy |
| dump_wave_o | output | 1 | Frequency-encoded status wave |

## Verification
The bench builds the block with 4 channels, 3 windows, a 2-bit energy index, 12-bit sums and DIV_NOM of 4. At these values the whole 48-entry threshold table can be written from a formula, and the 2-bit window field can address the out-of-range window 3. Both status-wave half-periods, 4 and 8 cycles, are then short enough to measure directly. A table of vectors covers the equal-to-threshold case, energy-column selection, and each mask encoding with the safe flag both high and low. Directed tests cover locking, latching, the simultaneous clear-and-trip case, the wave rates and the sticky failure state.

// File: rtl/loss_dump_pkg.sv
package loss_dump_pkg;

    typedef enum logic [1:0] {
        ST_LOAD  = 2'd0,
        ST_ARMED = 2'd1,
        ST_DUMP  = 2'd2,
        ST_FAULT = 2'd3
    } dump_state_e;

    // Mask entry: bit 0 enables masking, bit 1 forces the channel onto the unmaskable request
    typedef struct packed {
        logic force_unmask;
        logic mask_en;
    } chan_mask_t;

endpackage

// File: rtl/loss_thr_table.sv
module loss_thr_table
    import loss_dump_pkg::*;
#(
    parameter int NUM_CH   = 8,
    parameter int NUM_WIN  = 12,
    parameter int ENERGY_W = 4,
    parameter int SUM_W    = 24,
    parameter int CH_W     = 3,
    parameter int WIN_W    = 4
) (
    input  logic                clk,
    input  logic                wr_allow,
    input  logic                wr_en,
    input  logic                wr_is_mask,
    input  logic [CH_W-1:0]     wr_ch,
    input  logic [WIN_W-1:0]    wr_win,
    input  logic [ENERGY_W-1:0] wr_energy,
    input  logic [SUM_W-1:0]    wr_data,
    input  logic [ENERGY_W-1:0] beam_energy,
    input  logic                safe_beam,
    input  logic [CH_W-1:0]     sum_ch,
    input  logic [WIN_W-1:0]    sum_win,
    input  logic [SUM_W-1:0]    sum_value,
    output logic                hit_mask,
    output logic                hit_unmask
);

    localparam int NUM_E = 1 << ENERGY_W;
    localparam int DEPTH = NUM_CH * NUM_WIN * NUM_E;
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [SUM_W-1:0] thr_mem  [DEPTH];
    chan_mask_t       mask_mem [NUM_CH];

    function automatic logic [IDX_W-1:0] flat_idx(
        input logic [CH_W-1:0]     ch,
        input logic [WIN_W-1:0]    win,
        input logic [ENERGY_W-1:0] en
    );
        int v;
        v = (int'(ch) * NUM_WIN + int'(win)) * NUM_E + int'(en);
        return IDX_W'(v);
    endfunction

    logic wr_ch_ok, wr_win_ok;
    assign wr_ch_ok  = int'(wr_ch) < NUM_CH;
    assign wr_win_ok = int'(wr_win) < NUM_WIN;

    always_ff @(posedge clk) begin
        if (wr_allow && wr_en && wr_ch_ok) begin
            if (wr_is_mask) begin
                mask_mem[wr_ch] <= chan_mask_t'(wr_data[1:0]);
            end else if (wr_win_ok) begin
                thr_mem[flat_idx(wr_ch, wr_win, wr_energy)] <= wr_data;
            end
        end
    end

    logic             rd_ok;
    logic [CH_W-1:0]  rd_ch;
    logic [WIN_W-1:0] rd_win;
    logic [SUM_W-1:0] thr_sel;
    chan_mask_t       m_sel;
    logic             exceed;
    logic             to_unmask;

    always_comb begin
        rd_ok     = (int'(sum_ch) < NUM_CH) && (int'(sum_win) < NUM_WIN);
        rd_ch     = rd_ok ? sum_ch  : '0;
        rd_win    = rd_ok ? sum_win : '0;
        thr_sel   = thr_mem[flat_idx(rd_ch, rd_win, beam_energy)];
        m_sel     = mask_mem[rd_ch];
        exceed    = rd_ok && (sum_value > thr_sel);
        to_unmask = !m_sel.mask_en || m_sel.force_unmask;
        hit_unmask = exceed && to_unmask;
        hit_mask   = exceed && !to_unmask && !safe_beam;
    end

endmodule

// File: rtl/loss_dump_fsm.sv
module loss_dump_fsm
    import loss_dump_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load_done,
    input  logic        fault_in,
    input  logic        sum_valid,
    input  logic        hit_mask,
    input  logic        hit_unmask,
    input  logic        dump_clear,
    output dump_state_e state_o,
    output logic        mdump_o,
    output logic        udump_o,
    output logic        running_o
);

    dump_state_e state_q, state_d;
    logic        mdump_q, udump_q;
    logic        eval, trip_m, trip_u;

    // Next-state and latch update
    always_comb begin
        eval   = sum_valid && ((state_q == ST_ARMED) || (state_q == ST_DUMP));
        trip_m = eval && hit_mask;
        trip_u = eval && hit_unmask;
        state_d = state_q;
        unique case (state_q)
            ST_LOAD: begin
                if (fault_in)       state_d = ST_FAULT;   // T_FAIL
                else if (load_done) state_d = ST_ARMED;   // T_LOADED
            end
            ST_ARMED: begin
                if (fault_in)                state_d = ST_FAULT; // T_FAIL
                else if (trip_m || trip_u)   state_d = ST_DUMP;  // T_TRIP
            end
            ST_DUMP: begin
                if (fault_in)                              state_d = ST_FAULT; // T_FAIL
                else if (dump_clear && !(trip_m || trip_u)) state_d = ST_ARMED; // T_CLEAR
            end
            ST_FAULT: state_d = ST_FAULT;
            default:  state_d = ST_FAULT;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_LOAD;
            mdump_q <= 1'b0;
            udump_q <= 1'b0;
        end else begin
            state_q <= state_d;
            mdump_q <= (mdump_q && !dump_clear) || trip_m;
            udump_q <= (udump_q && !dump_clear) || trip_u;
        end
    end

    // Outputs
    always_comb begin
        state_o   = state_q;
        mdump_o   = mdump_q;
        udump_o   = udump_q;
        running_o = (state_q == ST_ARMED) || (state_q == ST_DUMP);
    end

    a_r3_load_ignores: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOAD && !mdump_q && !udump_q) |=> !(mdump_q || udump_q));
    a_r7_hold_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (mdump_q && !dump_clear) |=> mdump_q);
    a_r7_hold_unmask: assert property (@(posedge clk) disable iff (!rst_n)
        (udump_q && !dump_clear) |=> udump_q);
    a_r7_dump_has_request: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DUMP) |-> (mdump_q || udump_q));
    a_r10_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FAULT) |=> (state_q == ST_FAULT));
    a_r10_fault_stops_run: assert property (@(posedge clk) disable iff (!rst_n)
        fault_in |=> !running_o);

endmodule

// File: rtl/loss_freq_encoder.sv
module loss_freq_encoder #(
    parameter int DIV_NOM = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic slow,
    output logic wave_o
);

    localparam int CNT_W = $clog2(2 * DIV_NOM + 1);
    localparam logic [CNT_W-1:0] LIM_FAST = CNT_W'(DIV_NOM);
    localparam logic [CNT_W-1:0] LIM_SLOW = CNT_W'(2 * DIV_NOM);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim;
    logic             slow_q;
    logic             wave_q;

    assign lim = slow ? LIM_SLOW : LIM_FAST;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            wave_q <= 1'b0;
            slow_q <= 1'b0;
        end else if (!run) begin
            cnt    <= '0;
            wave_q <= 1'b0;
            slow_q <= slow;
        end else if (slow != slow_q) begin
            cnt    <= '0;
            slow_q <= slow;
        end else if (cnt == lim - 1'b1) begin
            cnt    <= '0;
            wave_q <= !wave_q;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign wave_o = wave_q;

    a_r9_stopped_low: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !wave_q);
    a_r9_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < LIM_SLOW);

endmodule

// File: rtl/loss_dump_ctrl.sv
module loss_dump_ctrl
    import loss_dump_pkg::*;
#(
    parameter int NUM_CH   = 8,
    parameter int NUM_WIN  = 12,
    parameter int ENERGY_W = 4,
    parameter int SUM_W    = 24,
    parameter int DIV_NOM  = 1000,
    localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int WIN_W   = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tbl_wr_en,
    input  logic                tbl_wr_is_mask,
    input  logic [CH_W-1:0]     tbl_wr_ch,
    input  logic [WIN_W-1:0]    tbl_wr_win,
    input  logic [ENERGY_W-1:0] tbl_wr_energy,
    input  logic [SUM_W-1:0]    tbl_wr_data,
    input  logic                tbl_load_done,
    input  logic [ENERGY_W-1:0] beam_energy,
    input  logic                safe_beam,
    input  logic                sum_valid,
    input  logic [CH_W-1:0]     sum_ch,
    input  logic [WIN_W-1:0]    sum_win,
    input  logic [SUM_W-1:0]    sum_value,
    input  logic                dump_clear,
    input  logic                fault_in,
    output logic                maskable_dump_o,
    output logic                unmaskable_dump_o,
    output logic                card_running_o,
    output logic                dump_wave_o
);

    dump_state_e state;
    logic        hit_mask, hit_unmask;

    loss_thr_table #(
        .NUM_CH(NUM_CH), .NUM_WIN(NUM_WIN), .ENERGY_W(ENERGY_W),
        .SUM_W(SUM_W), .CH_W(CH_W), .WIN_W(WIN_W)
    ) u_table (
        .clk        (clk),
        .wr_allow   (state == ST_LOAD),
        .wr_en      (tbl_wr_en),
        .wr_is_mask (tbl_wr_is_mask),
        .wr_ch      (tbl_wr_ch),
        .wr_win     (tbl_wr_win),
        .wr_energy  (tbl_wr_energy),
        .wr_data    (tbl_wr_data),
        .beam_energy(beam_energy),
        .safe_beam  (safe_beam),
        .sum_ch     (sum_ch),
        .sum_win    (sum_win),
        .sum_value  (sum_value),
        .hit_mask   (hit_mask),
        .hit_unmask (hit_unmask)
    );

    loss_dump_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_done (tbl_load_done),
        .fault_in  (fault_in),
        .sum_valid (sum_valid),
        .hit_mask  (hit_mask),
        .hit_unmask(hit_unmask),
        .dump_clear(dump_clear),
        .state_o   (state),
        .mdump_o   (maskable_dump_o),
        .udump_o   (unmaskable_dump_o),
        .running_o (card_running_o)
    );

    loss_freq_encoder #(.DIV_NOM(DIV_NOM)) u_wave (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (card_running_o),
        .slow  (state == ST_DUMP),
        .wave_o(dump_wave_o)
    );

    a_r5_safe_blocks_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (!maskable_dump_o && safe_beam) |=> !maskable_dump_o);
    a_r8_running_needs_load: assert property (@(posedge clk) disable iff (!rst_n)
        (!card_running_o && !tbl_load_done) |=> !card_running_o);

endmodule

// File: tb/test_loss_dump_ctrl.sv
`timescale 1ns/1ps
module test_loss_dump_ctrl;

    localparam int NUM_CH = 4, NUM_WIN = 3, ENERGY_W = 2, SUM_W = 12, DIV_NOM = 4;
    localparam int CH_W = 2, WIN_W = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tbl_wr_en = 0, tbl_wr_is_mask = 0, tbl_load_done = 0;
    logic [CH_W-1:0] tbl_wr_ch = '0, sum_ch = '0;
    logic [WIN_W-1:0] tbl_wr_win = '0, sum_win = '0;
    logic [ENERGY_W-1:0] tbl_wr_energy = '0, beam_energy = '0;
    logic [SUM_W-1:0] tbl_wr_data = '0, sum_value = '0;
    logic safe_beam = 0, sum_valid = 0, dump_clear = 0, fault_in = 0;
    logic mdump, udump, running, wave;

    always #4 clk = ~clk;

    loss_dump_ctrl #(
        .NUM_CH(NUM_CH), .NUM_WIN(NUM_WIN), .ENERGY_W(ENERGY_W),
        .SUM_W(SUM_W), .DIV_NOM(DIV_NOM)
    ) i_loss_dump_ctrl (
        .clk(clk), .rst_n(rst_n),
        .tbl_wr_en(tbl_wr_en), .tbl_wr_is_mask(tbl_wr_is_mask),
        .tbl_wr_ch(tbl_wr_ch), .tbl_wr_win(tbl_wr_win),
        .tbl_wr_energy(tbl_wr_energy), .tbl_wr_data(tbl_wr_data),
        .tbl_load_done(tbl_load_done), .beam_energy(beam_energy),
        .safe_beam(safe_beam), .sum_valid(sum_valid), .sum_ch(sum_ch),
        .sum_win(sum_win), .sum_value(sum_value), .dump_clear(dump_clear),
        .fault_in(fault_in), .maskable_dump_o(mdump),
        .unmaskable_dump_o(udump), .card_running_o(running),
        .dump_wave_o(wave)
    );

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    // Vector: ch[20:19] win[18:17] energy[16:15] sum[14:3] safe[2] exp_mask[1] exp_unmask[0]
    localparam int NVEC = 10;
    localparam logic [20:0] VECS [NVEC] = '{
        {2'd0, 2'd1, 2'd2, 12'd112,  1'b0, 1'b0, 1'b0},  // R4 equal: no trip
        {2'd0, 2'd1, 2'd2, 12'd113,  1'b0, 1'b0, 1'b1},  // R6 unmasked channel
        {2'd1, 2'd0, 2'd0, 12'd201,  1'b0, 1'b1, 1'b0},  // R5 masked, unsafe
        {2'd1, 2'd0, 2'd0, 12'd201,  1'b1, 1'b0, 1'b0},  // R5 masked, safe
        {2'd2, 2'd2, 2'd3, 12'd324,  1'b1, 1'b0, 1'b1},  // R6 forced overrides mask
        {2'd3, 2'd2, 2'd1, 12'd422,  1'b1, 1'b0, 1'b1},  // R6 forced only
        {2'd1, 2'd2, 2'd3, 12'd223,  1'b0, 1'b0, 1'b0},  // R4 equal
        {2'd1, 2'd2, 2'd0, 12'd221,  1'b0, 1'b1, 1'b0},  // R4 energy column 0
        {2'd1, 2'd2, 2'd3, 12'd221,  1'b0, 1'b0, 1'b0},  // R4 energy column 3
        {2'd0, 2'd3, 2'd0, 12'd4095, 1'b0, 1'b0, 1'b0}   // R4 window out of range
    };

    function automatic int thr_of(input int ch, input int w, input int e);
        return 100 * (ch + 1) + 10 * w + e;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic write_entry(input logic is_mask, input int ch, input int w,
                               input int e, input int data);
        tbl_wr_en = 1; tbl_wr_is_mask = is_mask;
        tbl_wr_ch = CH_W'(ch); tbl_wr_win = WIN_W'(w);
        tbl_wr_energy = ENERGY_W'(e); tbl_wr_data = SUM_W'(data);
        @(negedge clk);
        tbl_wr_en = 0;
    endtask

    task automatic apply_sum(input int ch, input int w, input int e,
                             input int s, input logic safe);
        sum_ch = CH_W'(ch); sum_win = WIN_W'(w); beam_energy = ENERGY_W'(e);
        sum_value = SUM_W'(s); safe_beam = safe; sum_valid = 1;
        @(negedge clk);
        sum_valid = 0;
    endtask

    task automatic pulse_clear();
        dump_clear = 1;
        @(negedge clk);
        dump_clear = 0;
    endtask

    task automatic half_period(output int n);
        logic prev;
        n = 0;
        prev = wave;
        for (int k = 0; k < 100 && wave == prev; k++) @(negedge clk);
        prev = wave;
        for (int k = 0; k < 100 && wave == prev; k++) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        int hp;
        int bad;
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check("R1 reset outputs", {mdump, udump, running, wave}, 0);
        repeat (10) @(negedge clk);
        check("R1 wave idle before load", {running, wave}, 0);

        // R3 sums ignored before load
        apply_sum(0, 0, 0, 4000, 0);
        check("R3 sum before load", {mdump, udump}, 0);

        // Load tables
        for (int c = 0; c < NUM_CH; c++)
            for (int w = 0; w < NUM_WIN; w++)
                for (int e = 0; e < (1 << ENERGY_W); e++)
                    write_entry(0, c, w, e, thr_of(c, w, e));
        write_entry(1, 0, 0, 0, 0);
        write_entry(1, 1, 0, 0, 1);
        write_entry(1, 2, 0, 0, 3);
        write_entry(1, 3, 0, 0, 2);
        tbl_load_done = 1;
        @(negedge clk);
        tbl_load_done = 0;
        check("R8 running after load", running, 1);

        // R2 writes after lock ignored
        write_entry(0, 0, 0, 0, 0);
        write_entry(1, 1, 0, 0, 0);
        apply_sum(0, 0, 0, 50, 0);
        check("R2 locked threshold write", {mdump, udump}, 0);
        apply_sum(1, 0, 0, 201, 0);
        check("R2 locked mask write", {mdump, udump}, 2);
        pulse_clear();

        // Vector table
        for (int i = 0; i < NVEC; i++) begin
            logic [20:0] v;
            v = VECS[i];
            apply_sum(int'(v[20:19]), int'(v[18:17]), int'(v[16:15]),
                      int'(v[14:3]), v[2]);
            check($sformatf("R4/R5/R6 vector %0d", i), {mdump, udump}, int'(v[1:0]));
            pulse_clear();
        end

        // R7 latch hold and clear
        apply_sum(0, 0, 0, 500, 0);
        repeat (10) @(negedge clk);
        check("R7 request held", {mdump, udump, running}, 3'b011);
        // clear plus new maskable trip in the same cycle
        dump_clear = 1;
        apply_sum(1, 0, 0, 201, 0);
        dump_clear = 0;
        check("R7 clear with simultaneous trip", {mdump, udump}, 2);
        pulse_clear();
        check("R7 cleared", {mdump, udump}, 0);

        // R9 wave rates
        half_period(hp);
        half_period(hp);
        check("R9 armed half period", hp, DIV_NOM);
        apply_sum(0, 0, 0, 500, 0);
        repeat (3) @(negedge clk);
        half_period(hp);
        half_period(hp);
        check("R9 dump half period", hp, 2 * DIV_NOM);
        pulse_clear();
        check("R8 running in armed", running, 1);

        // R10 failure
        fault_in = 1;
        @(negedge clk);
        fault_in = 0;
        @(negedge clk);
        bad = 0;
        for (int k = 0; k < 20; k++) begin
            if (wave !== 1'b0 || running !== 1'b0) bad++;
            @(negedge clk);
        end
        check("R10 fault wave and running low", bad, 0);
        apply_sum(0, 0, 0, 500, 0);
        check("R10 sum ignored in fault", {mdump, udump}, 0);
        tbl_load_done = 1;
        @(negedge clk);
        tbl_load_done = 0;
        check("R10 fault sticky", running, 0);

        // R1 reset recovers
        rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R1 reset after fault", {mdump, udump, running, wave}, 0);

        finished = 1;
        summary();
        $finish;
    end

endmodule